// File: doc/BRIEF.md
# Payload Envelope and Path Trace Marker Generator

This block follows the byte position inside a byte-interleaved STS-12 frame and marks each byte with two flags. `spe` says the byte belongs to a synchronous payload envelope, so downstream logic can keep payload bytes without decoding pointers. `c1j1` marks two things. With `spe` low it marks the single section-trace byte of the frame. With `spe` high it marks the first path-overhead byte of each STS-1. The block also exposes its row and column counters.

At each frame start the block samples a control set for each of the 12 tributaries: a payload pointer offset, a justification code, a path alarm flag and a concatenation-member flag. It holds these values for the whole frame. Justifications move the payload flag in and out of the stuff slots. A justification also moves the tributary's path-overhead marker by one byte in the next frame.

The block carries no data, only per-byte flags. It therefore has no valid/ready handshake and cannot apply back-pressure. It advances one byte on every clock, and the `frame_start` strobe re-aligns it.

Top module: `spe_flag_gen`

## Requirements
- R1: Position counting. When `frame_start` is high in a cycle, the next cycle shows `row_o`=0 and `col_o`=0. Otherwise `col_o` increases by 1 each cycle. It wraps from 1079 to 0 and then `row_o` advances, with row 8 wrapping to 0. Byte `col_o` belongs to tributary `col_o % 12`. Columns 0..35 are overhead and 36..1079 are payload.
- R2: Reset state. While and right after the synchronous active-high `rst`, `row_o`=0, `col_o`=0, `spe`=0 and `c1j1`=0.
- R3: Section-trace marker. (`spe`,`c1j1`)=(0,1) at row 0, column 24 only, once per frame. All other overhead bytes give (0,0), except as in R7.
- R4: Path-overhead marker. For tributary t with offset P, (1,1) appears at row (3 + P/87) mod 9 and column 36 + 12·(P mod 87) + t. Every other payload byte gives (1,0), except as in R8.
- R5: If bit t of `ais_in` was set at frame start, tributary t gets no R4 marker in that frame. That byte gives (1,0).
- R6: If bit t of `cmem_in` (a non-head member of a concatenated group) was set at frame start, tributary t gets no R4 marker. That byte gives (1,0).
- R7: Justification code 2'b01 (negative) for tributary t makes its H3 byte at row 3, column 24+t give (1,0).
- R8: Justification code 2'b10 (positive) for tributary t makes its stuff byte at row 3, column 36+t give (0,0). No marker is shown there.
- R9: Controls are sampled only in the `frame_start` cycle. Values present in any other cycle have no effect. Tributary t uses `ptr_in[10t+9:10t]`, `just_in[2t+1:2t]`, `ais_in[t]` and `cmem_in[t]`.
- R10: After a frame with code 2'b01, the next frame uses the previous offset minus 1 (0 becomes 782). After code 2'b10 it uses the previous offset plus 1 (782 becomes 0). `ptr_in` is ignored for that tributary in that case.
- R11: With no justification pending, a sampled offset above 782 is ignored and the previous offset is kept.
- R12: Code 2'b11 acts like 2'b00. The H3 and stuff bytes keep their normal flags, and the next offset is loaded from `ptr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Next byte is row 0, column 0; samples the controls |
| ptr_in | input | 120 | 12 × 10-bit payload pointer offsets |
| just_in | input | 24 | 12 × 2-bit justification codes |
| ais_in | input | 12 | Path alarm flag per tributary |
| cmem_in | input | 12 | Non-head concatenation member flag per tributary |
| spe | output | 1 | Byte is payload |
| c1j1 | output | 1 | Section-trace or path-overhead marker |
| row_o | output | 4 | Current row, 0..8 |
| col_o | output | 11 | Current byte slot in row, 0..1079 |

## Verification
The bench places pointers at the two wrap points, 0 and 782, and pairs them with justifications. A wrong modulo would put the marker in the wrong row or column in the next frame. It drives garbage controls between frame starts, which would expose logic that samples them continuously. Frames combine alarm, concatenation-member, reserved-code and out-of-range offsets, so a design that ignored a suppression or accepted a bad offset would show a marker in the wrong place. One frame is cut short by an early `frame_start`, which checks that the counters re-align instead of running on.

// File: rtl/spe_flag_pkg.sv
`timescale 1ns/1ps
package spe_flag_pkg;
  // Per-tributary justification code sampled at frame start.
  typedef enum logic [1:0] {
    JUST_NONE = 2'b00,
    JUST_NEG  = 2'b01,
    JUST_POS  = 2'b10,
    JUST_RSVD = 2'b11
  } just_e;
endpackage

// File: rtl/frame_pos_counter.sv
`timescale 1ns/1ps
module frame_pos_counter #(
  parameter int ROWS   = 9,
  parameter int GROUPS = 90,
  parameter int TRIBS  = 12,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int TRIB_W = $clog2(TRIBS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  output logic [ROW_W-1:0]  row,
  output logic [GRP_W-1:0]  grp,
  output logic [TRIB_W-1:0] trib
);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);
  localparam logic [GRP_W-1:0]  GRP_LAST  = GRP_W'(GROUPS - 1);
  localparam logic [TRIB_W-1:0] TRIB_LAST = TRIB_W'(TRIBS - 1);

  // Byte slot = grp * TRIBS + trib; tributary index runs fastest.
  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      row  <= '0;
      grp  <= '0;
      trib <= '0;
    end else if (trib == TRIB_LAST) begin
      trib <= '0;
      if (grp == GRP_LAST) begin
        grp <= '0;
        row <= (row == ROW_LAST) ? '0 : row + ROW_W'(1);
      end else begin
        grp <= grp + GRP_W'(1);
      end
    end else begin
      trib <= trib + TRIB_W'(1);
    end
  end
endmodule

// File: rtl/trib_ctx.sv
`timescale 1ns/1ps
module trib_ctx
  import spe_flag_pkg::*;
#(
  parameter int ROWS     = 9,
  parameter int PAY_COLS = 87,
  parameter int H3_ROW   = 3,
  parameter int PCOL_W   = 7,
  localparam int PTR_MAX = ROWS * PAY_COLS - 1,
  localparam int PTR_W   = $clog2(PTR_MAX + 1),
  localparam int ROW_W   = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic [1:0]        just_in,
  input  logic              ais_in,
  input  logic              cmem_in,
  output just_e             just_q,
  output logic              ais_q,
  output logic              cmem_q,
  output logic [ROW_W-1:0]  j1_row,
  output logic [PCOL_W-1:0] j1_pcol
);
  localparam logic [PTR_W-1:0] PTR_MAX_V = PTR_W'(PTR_MAX);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_nxt;

  // Offset for the coming frame: a justification in the frame now ending
  // steps the old offset and overrides the input; otherwise load if legal.
  always_comb begin
    unique case (just_q)
      JUST_NEG: ptr_nxt = (ptr_q == '0) ? PTR_MAX_V : ptr_q - PTR_W'(1);
      JUST_POS: ptr_nxt = (ptr_q == PTR_MAX_V) ? '0 : ptr_q + PTR_W'(1);
      default:  ptr_nxt = (ptr_in <= PTR_MAX_V) ? ptr_in : ptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      just_q <= JUST_NONE;
      ais_q  <= 1'b0;
      cmem_q <= 1'b0;
    end else if (frame_start) begin
      ptr_q  <= ptr_nxt;
      just_q <= just_e'(just_in);
      ais_q  <= ais_in;
      cmem_q <= cmem_in;
    end
  end

  // Offset 0 is the payload byte right after H3; rows wrap modulo ROWS.
  always_comb begin
    int unsigned quo;
    int unsigned rem;
    int unsigned rsum;
    quo  = 32'(ptr_q) / PAY_COLS;
    rem  = 32'(ptr_q) % PAY_COLS;
    rsum = quo + H3_ROW;
    if (rsum >= ROWS) rsum = rsum - ROWS;
    j1_row  = ROW_W'(rsum);
    j1_pcol = PCOL_W'(rem);
  end
endmodule

// File: rtl/flag_decode.sv
`timescale 1ns/1ps
module flag_decode
  import spe_flag_pkg::*;
#(
  parameter int TRIBS        = 12,
  parameter int OH_COLS      = 3,
  parameter int ROW_W        = 4,
  parameter int GRP_W        = 7,
  parameter int TRIB_W       = 4,
  parameter int H3_ROW       = 3,
  parameter int TRACE_ROW    = 0,
  parameter int TRACE_OH_COL = 2,
  parameter int TRACE_TRIB   = 0
) (
  input  logic [ROW_W-1:0]              row,
  input  logic [GRP_W-1:0]              grp,
  input  logic [TRIB_W-1:0]             trib,
  input  just_e [TRIBS-1:0]             just_q,
  input  logic [TRIBS-1:0]              ais_q,
  input  logic [TRIBS-1:0]              cmem_q,
  input  logic [TRIBS-1:0][ROW_W-1:0]   j1_row,
  input  logic [TRIBS-1:0][GRP_W-1:0]   j1_pcol,
  output logic                          spe,
  output logic                          c1j1
);
  localparam logic [GRP_W-1:0]  OH_V       = GRP_W'(OH_COLS);
  localparam logic [GRP_W-1:0]  H3_GRP_V   = GRP_W'(OH_COLS - 1);
  localparam logic [ROW_W-1:0]  H3_ROW_V   = ROW_W'(H3_ROW);
  localparam logic [ROW_W-1:0]  TR_ROW_V   = ROW_W'(TRACE_ROW);
  localparam logic [GRP_W-1:0]  TR_GRP_V   = GRP_W'(TRACE_OH_COL);
  localparam logic [TRIB_W-1:0] TR_TRIB_V  = TRIB_W'(TRACE_TRIB);

  logic             in_oh;
  logic [GRP_W-1:0] pcol;
  just_e            cur_just;
  logic             trace_hit, h3_hit, stuff_hit, pay_valid, j1_hit;

  always_comb begin
    in_oh     = grp < OH_V;
    pcol      = grp - OH_V;
    cur_just  = just_q[trib];
    trace_hit = (row == TR_ROW_V) && (grp == TR_GRP_V) && (trib == TR_TRIB_V);
    h3_hit    = (row == H3_ROW_V) && (grp == H3_GRP_V);
    stuff_hit = (row == H3_ROW_V) && (pcol == '0);
    pay_valid = !(stuff_hit && (cur_just == JUST_POS));
    j1_hit    = (row == j1_row[trib]) && (pcol == j1_pcol[trib]) &&
                !ais_q[trib] && !cmem_q[trib];
    if (in_oh) begin
      spe  = h3_hit && (cur_just == JUST_NEG);
      c1j1 = trace_hit;
    end else begin
      spe  = pay_valid;
      c1j1 = pay_valid && j1_hit;
    end
  end
endmodule

// File: rtl/spe_flag_gen.sv
`timescale 1ns/1ps
module spe_flag_gen
  import spe_flag_pkg::*;
#(
  parameter int TRIBS        = 12,
  parameter int OH_COLS      = 3,
  parameter int PAY_COLS     = 87,
  parameter int ROWS         = 9,
  parameter int H3_ROW       = 3,
  parameter int TRACE_ROW    = 0,
  parameter int TRACE_OH_COL = 2,
  parameter int TRACE_TRIB   = 0,
  localparam int GROUPS = OH_COLS + PAY_COLS,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int TRIB_W = $clog2(TRIBS),
  localparam int COL_W  = $clog2(GROUPS * TRIBS),
  localparam int PTR_W  = $clog2(ROWS * PAY_COLS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_start,
  input  logic [TRIBS*PTR_W-1:0] ptr_in,
  input  logic [TRIBS*2-1:0]     just_in,
  input  logic [TRIBS-1:0]       ais_in,
  input  logic [TRIBS-1:0]       cmem_in,
  output logic                   spe,
  output logic                   c1j1,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o
);
  logic [ROW_W-1:0]            row;
  logic [GRP_W-1:0]            grp;
  logic [TRIB_W-1:0]           trib;
  just_e [TRIBS-1:0]           just_q;
  logic [TRIBS-1:0]            ais_q;
  logic [TRIBS-1:0]            cmem_q;
  logic [TRIBS-1:0][ROW_W-1:0] j1_row;
  logic [TRIBS-1:0][GRP_W-1:0] j1_pcol;

  frame_pos_counter #(
    .ROWS(ROWS), .GROUPS(GROUPS), .TRIBS(TRIBS)
  ) u_pos (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .row(row), .grp(grp), .trib(trib)
  );

  for (genvar i = 0; i < TRIBS; i++) begin : g_trib
    trib_ctx #(
      .ROWS(ROWS), .PAY_COLS(PAY_COLS), .H3_ROW(H3_ROW), .PCOL_W(GRP_W)
    ) u_ctx (
      .clk(clk), .rst(rst), .frame_start(frame_start),
      .ptr_in(ptr_in[i*PTR_W +: PTR_W]),
      .just_in(just_in[i*2 +: 2]),
      .ais_in(ais_in[i]),
      .cmem_in(cmem_in[i]),
      .just_q(just_q[i]),
      .ais_q(ais_q[i]),
      .cmem_q(cmem_q[i]),
      .j1_row(j1_row[i]),
      .j1_pcol(j1_pcol[i])
    );
  end

  flag_decode #(
    .TRIBS(TRIBS), .OH_COLS(OH_COLS), .ROW_W(ROW_W), .GRP_W(GRP_W),
    .TRIB_W(TRIB_W), .H3_ROW(H3_ROW), .TRACE_ROW(TRACE_ROW),
    .TRACE_OH_COL(TRACE_OH_COL), .TRACE_TRIB(TRACE_TRIB)
  ) u_dec (
    .row(row), .grp(grp), .trib(trib),
    .just_q(just_q), .ais_q(ais_q), .cmem_q(cmem_q),
    .j1_row(j1_row), .j1_pcol(j1_pcol),
    .spe(spe), .c1j1(c1j1)
  );

  assign row_o = row;
  assign col_o = COL_W'(grp) * COL_W'(TRIBS) + COL_W'(trib);
endmodule

// File: rtl/spe_flag_gen_chk.sv
`timescale 1ns/1ps
module spe_flag_gen_chk #(
  parameter int TRIBS        = 12,
  parameter int OH_COLS      = 3,
  parameter int PAY_COLS     = 87,
  parameter int ROWS         = 9,
  parameter int H3_ROW       = 3,
  parameter int TRACE_ROW    = 0,
  parameter int TRACE_OH_COL = 2,
  parameter int TRACE_TRIB   = 0,
  localparam int GROUPS = OH_COLS + PAY_COLS,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int TRIB_W = $clog2(TRIBS),
  localparam int COL_W  = $clog2(GROUPS * TRIBS)
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic [TRIBS-1:0] ais_in,
  input logic [TRIBS-1:0] cmem_in,
  input logic             spe,
  input logic             c1j1,
  input logic [ROW_W-1:0] row_o,
  input logic [COL_W-1:0] col_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(GROUPS * TRIBS - 1);
  localparam logic [COL_W-1:0] OH_END   = COL_W'(OH_COLS * TRIBS);
  localparam logic [COL_W-1:0] H3_FIRST = COL_W'((OH_COLS - 1) * TRIBS);
  localparam logic [COL_W-1:0] TR_COL   = COL_W'(TRACE_OH_COL * TRIBS + TRACE_TRIB);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [ROW_W-1:0] H3_ROW_V = ROW_W'(H3_ROW);
  localparam logic [ROW_W-1:0] TR_ROW_V = ROW_W'(TRACE_ROW);

  logic [TRIBS-1:0]  ais_s, cmem_s;
  logic [TRIB_W-1:0] tslot;

  always_ff @(posedge clk) begin
    if (rst) begin
      ais_s  <= '0;
      cmem_s <= '0;
    end else if (frame_start) begin
      ais_s  <= ais_in;
      cmem_s <= cmem_in;
    end
  end

  assign tslot = TRIB_W'(col_o % COL_W'(TRIBS));

  assert_pos_range_R1: assert property (@(posedge clk) disable iff (rst)
    (row_o <= ROW_LAST) && (col_o <= COL_LAST));

  assert_fs_origin_R1: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (row_o == '0) && (col_o == '0));

  assert_col_step_R1: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && col_o != COL_LAST) |=>
      (col_o == $past(col_o) + COL_W'(1)) && (row_o == $past(row_o)));

  assert_row_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && col_o == COL_LAST) |=>
      (col_o == '0) &&
      (row_o == (($past(row_o) == ROW_LAST) ? '0 : $past(row_o) + ROW_W'(1))));

  assert_trace_only_R3: assert property (@(posedge clk) disable iff (rst)
    (c1j1 && !spe) |-> (row_o == TR_ROW_V) && (col_o == TR_COL));

  assert_trace_present_R3: assert property (@(posedge clk) disable iff (rst)
    ((row_o == TR_ROW_V) && (col_o == TR_COL)) |-> (c1j1 && !spe));

  assert_oh_payload_R7: assert property (@(posedge clk) disable iff (rst)
    (spe && col_o < OH_END) |-> (row_o == H3_ROW_V) && (col_o >= H3_FIRST));

  assert_pay_gap_R8: assert property (@(posedge clk) disable iff (rst)
    (!spe && col_o >= OH_END) |->
      (row_o == H3_ROW_V) && (col_o < OH_END + COL_W'(TRIBS)) && !c1j1);

  assert_no_j1_alarm_R5: assert property (@(posedge clk) disable iff (rst)
    (spe && c1j1) |-> !ais_s[tslot]);

  assert_no_j1_member_R6: assert property (@(posedge clk) disable iff (rst)
    (spe && c1j1) |-> !cmem_s[tslot]);
endmodule

bind spe_flag_gen spe_flag_gen_chk #(
  .TRIBS(TRIBS), .OH_COLS(OH_COLS), .PAY_COLS(PAY_COLS), .ROWS(ROWS),
  .H3_ROW(H3_ROW), .TRACE_ROW(TRACE_ROW), .TRACE_OH_COL(TRACE_OH_COL),
  .TRACE_TRIB(TRACE_TRIB)
) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start),
  .ais_in(ais_in), .cmem_in(cmem_in),
  .spe(spe), .c1j1(c1j1), .row_o(row_o), .col_o(col_o)
);

// File: tb/test_spe_flag_gen.sv
`timescale 1ns/1ps
module test_spe_flag_gen;
  localparam int TRIBS = 12;
  localparam int PW    = 10;
  localparam int NROW  = 9;
  localparam int NCOL  = 1080;
  localparam int PMAX  = 782;
  localparam int FLEN  = NROW * NCOL;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst;
  logic                   frame_start;
  logic [TRIBS*PW-1:0]    ptr_in;
  logic [TRIBS*2-1:0]     just_in;
  logic [TRIBS-1:0]       ais_in, cmem_in;
  logic                   spe, c1j1;
  logic [3:0]             row_o;
  logic [10:0]            col_o;

  spe_flag_gen i_spe_flag_gen (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .ptr_in(ptr_in), .just_in(just_in), .ais_in(ais_in), .cmem_in(cmem_in),
    .spe(spe), .c1j1(c1j1), .row_o(row_o), .col_o(col_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  int    m_row, m_col;
  int    m_ptr  [TRIBS];
  int    m_just [TRIBS];
  bit    m_ais  [TRIBS];
  bit    m_cmem [TRIBS];
  string m_tag  [TRIBS];
  bit    r9_frame = 1'b0;

  // Expected flags for a byte, derived from the requirement text.
  function automatic void expect_flags(input int r, input int c,
                                       output bit s, output bit m,
                                       output string tag);
    int t, g, pc, jr, jc;
    t = c % TRIBS;
    g = c / TRIBS;
    s = 1'b0; m = 1'b0; tag = "R3";
    if (g < 3) begin
      if (r == 0 && c == 24) m = 1'b1;                      // R3
      else if (r == 3 && g == 2) begin                      // R7 / R12
        tag = (m_just[t] == 3) ? "R12" : "R7";
        s = (m_just[t] == 1);
      end
    end else begin
      pc = g - 3;
      s = 1'b1; tag = "R4";
      if (r == 3 && pc == 0) begin                          // R8 / R12
        tag = (m_just[t] == 3) ? "R12" : "R8";
        if (m_just[t] == 2) s = 1'b0;
      end
      jr = (3 + m_ptr[t] / 87) % 9;
      jc = m_ptr[t] % 87;
      if (r == jr && pc == jc) begin
        tag = m_tag[t];
        if (m_ais[t] && tag == "R4") tag = "R5";
        else if (m_cmem[t] && tag == "R4") tag = "R6";
        m = s && !m_ais[t] && !m_cmem[t];
      end
    end
  endfunction

  // Model update at a frame start (R9, R10, R11, R12).
  task automatic apply_fs();
    for (int t = 0; t < TRIBS; t++) begin
      int pi;
      pi = int'(ptr_in[t*PW +: PW]);
      if (m_just[t] == 1) begin
        m_ptr[t] = (m_ptr[t] == 0) ? PMAX : m_ptr[t] - 1; m_tag[t] = "R10";
      end else if (m_just[t] == 2) begin
        m_ptr[t] = (m_ptr[t] == PMAX) ? 0 : m_ptr[t] + 1; m_tag[t] = "R10";
      end else if (pi <= PMAX) begin
        m_ptr[t] = pi; m_tag[t] = r9_frame ? "R9" : "R4";
      end else begin
        m_tag[t] = "R11";
      end
      m_just[t] = int'(just_in[t*2 +: 2]);
      m_ais[t]  = ais_in[t];
      m_cmem[t] = cmem_in[t];
    end
  endtask

  task automatic garbage();
    for (int t = 0; t < TRIBS; t++) ptr_in[t*PW +: PW] = PW'($urandom);
    just_in = 24'($urandom);
    ais_in  = 12'($urandom);
    cmem_in = 12'($urandom);
  endtask

  // Called at a falling edge: check current byte, drive, advance model.
  task automatic tick(input bit fsv);
    bit es, em;
    string tg;
    n_cmp++;
    if (row_o !== 4'(m_row) || col_o !== 11'(m_col)) begin
      n_bad++;
      $display("FAIL R1 position: actual row=%0d col=%0d expected row=%0d col=%0d",
               row_o, col_o, m_row, m_col);
    end
    expect_flags(m_row, m_col, es, em, tg);
    n_cmp++;
    if (spe !== es || c1j1 !== em) begin
      n_bad++;
      $display("FAIL %s at row %0d col %0d: actual spe=%0b c1j1=%0b expected spe=%0b c1j1=%0b",
               tg, m_row, m_col, spe, c1j1, es, em);
    end
    frame_start = fsv;
    if (fsv) begin
      apply_fs();
      m_row = 0; m_col = 0;
    end else begin
      garbage();
      m_col++;
      if (m_col == NCOL) begin m_col = 0; m_row = (m_row + 1) % NROW; end
    end
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  task automatic rand_ctl();
    for (int t = 0; t < TRIBS; t++) begin
      ptr_in[t*PW +: PW] = PW'($urandom % (PMAX + 1));
      just_in[t*2 +: 2]  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
    end
    ais_in  = 12'($urandom) & 12'($urandom);
    cmem_in = 12'($urandom) & 12'($urandom);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; frame_start = 1'b0;
    ptr_in = '0; just_in = '0; ais_in = '0; cmem_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    n_cmp++;
    if (row_o !== 4'd0 || col_o !== 11'd0 || spe !== 1'b0 || c1j1 !== 1'b0) begin
      n_bad++;
      $display("FAIL R2 reset: actual row=%0d col=%0d spe=%0b c1j1=%0b expected 0 0 0 0",
               row_o, col_o, spe, c1j1);
    end
    m_row = 0; m_col = 0;
    for (int t = 0; t < TRIBS; t++) begin
      m_ptr[t] = 0; m_just[t] = 0; m_ais[t] = 0; m_cmem[t] = 0; m_tag[t] = "R4";
    end
    // Free run past a full frame: R1 wrap without frame_start, R9 garbage.
    run(FLEN + 40);

    // Frame A: spread offsets, alarm, concatenation members, reserved code.
    for (int t = 0; t < TRIBS; t++) ptr_in[t*PW +: PW] = PW'(t * 65);
    just_in = '0; just_in[9*2 +: 2] = 2'b11;               // R12
    ais_in  = 12'h020;                                     // R5
    cmem_in = 12'h00C;                                     // R6
    tick(1'b1); run(FLEN - 1);

    // Frame B: justifications at the offset wrap points (R7, R8).
    rand_ctl(); ais_in = '0; cmem_in = '0; just_in = '0;
    ptr_in[0*PW +: PW] = PW'(0);   just_in[0*2 +: 2] = 2'b01;
    ptr_in[1*PW +: PW] = PW'(782); just_in[1*2 +: 2] = 2'b10;
    ptr_in[4*PW +: PW] = PW'(300); just_in[4*2 +: 2] = 2'b01;
    ptr_in[7*PW +: PW] = PW'(500); just_in[7*2 +: 2] = 2'b10;
    tick(1'b1); run(FLEN - 1);

    // Frame C: stepped offsets override input (R10), bad offset kept (R11).
    rand_ctl(); just_in = '0;
    ptr_in[6*PW +: PW] = PW'(900);
    tick(1'b1); run(FLEN - 1);

    // Frame D: mid-frame garbage ignored (R9), cut short by early resync (R1).
    r9_frame = 1'b1;
    rand_ctl();
    tick(1'b1); run(5000);
    r9_frame = 1'b0;

    // Random frames.
    for (int f = 0; f < 3; f++) begin
      rand_ctl();
      tick(1'b1); run(FLEN - 1);
    end
    run(20);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule